// File: doc/BRIEF.md
# Register write-protection gate with two-key unlock

This block sits on the write path between a bus and a peripheral's register file. It examines every write. Writes aimed at a fixed set of protected addresses reach the registers only while the file is unlocked. Writes to all other addresses pass through unchanged. Reads go straight through, except at the two key locations, which always return zero.

The file unlocks only while two key slots both hold their correct 32-bit magic words. Software normally loads key slot 0 and then key slot 1. It locks the file again by writing zero, or any other wrong value, to a key slot. The gate absorbs key writes itself and never forwards them to the registers it protects.

Top module: `wpg_write_gate`

## Requirements
- R1: After reset the file is locked: `unlocked_o` is 0 and both key slots are cleared. The lock state changes only on a write to a key address.
- R2: The file unlocks when key slot 0 (byte address 0x6C) holds 0x83E70B13 and key slot 1 (byte address 0x70) holds 0x95A4F1E0. `unlocked_o` rises in the cycle after the write that completes the pair. The two slots may be loaded in either order.
- R3: A write of any other value to a key address clears that slot. The file is locked from the next cycle.
- R4: While the file is locked, a write to a protected address is dropped (`wr_en_o` stays 0) and no error is raised.
- R5: While the file is unlocked, a write to a protected address is forwarded in the same cycle, with its address and data unchanged.
- R6: Writes to unprotected addresses are forwarded whatever the lock state. These include 0x40, 0x4C, 0x50, 0x58 and 0x1C.
- R7: Writes to either key address are never forwarded (`wr_en_o` stays 0).
- R8: A read at either key address returns 0. A read at any other address returns `rd_data_i` unchanged in the same cycle.
- R9: The protected byte addresses are the ranges 0x00–0x18, 0x20–0x34, 0x44–0x48, 0x54, 0x60–0x68, 0x7C and 0x80–0x98, each range inclusive. No other address is protected.
- R10: A correct word in only one slot leaves the file locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 8 | Bus write byte address |
| wr_data_i | input | 32 | Bus write data |
| rd_addr_i | input | 8 | Bus read byte address |
| rd_data_i | input | 32 | Read data from the register file |
| wr_en_o | output | 1 | Filtered write enable to the register file |
| wr_addr_o | output | 8 | Write address passed to the register file |
| wr_data_o | output | 32 | Write data passed to the register file |
| rd_data_o | output | 32 | Read data returned to the bus |
| unlocked_o | output | 1 | High while both key slots hold their magic words |

## Verification
The read mask and the write gate act in the same cycle on independent addresses. The bench therefore drives a read of a key address in the same cycle that the matching magic word is written there, and requires zero on the read side while the write is absorbed. It also reads a protected register in the same cycle that a write to it is dropped or forwarded, and compares the read and the filtered enable in that cycle against a behavioural model. The model tracks the lock state cycle by cycle, so a write issued in the cycle right after a relock must be blocked.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] KEY0_ADDR  = 8'h6C;
  localparam logic [ADDR_W-1:0] KEY1_ADDR  = 8'h70;
  localparam logic [DATA_W-1:0] KEY0_MAGIC = 32'h83E70B13;
  localparam logic [DATA_W-1:0] KEY1_MAGIC = 32'h95A4F1E0;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } win_t;

  localparam int NWIN = 7;
  localparam win_t PROT_WIN [NWIN] = '{
    '{lo: 8'h00, hi: 8'h18},
    '{lo: 8'h20, hi: 8'h34},
    '{lo: 8'h44, hi: 8'h48},
    '{lo: 8'h54, hi: 8'h54},
    '{lo: 8'h60, hi: 8'h68},
    '{lo: 8'h7C, hi: 8'h7C},
    '{lo: 8'h80, hi: 8'h98}
  };
endpackage

// File: rtl/wpg_rst_sync.sv
module wpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wpg_prot_decode.sv
module wpg_prot_decode
  import wpg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o,
  output logic              key_o
);
  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = (addr_i >= PROT_WIN[w].lo) && (addr_i <= PROT_WIN[w].hi);
  end

  assign prot_o = |hit;
  assign key_o  = (addr_i == KEY0_ADDR) || (addr_i == KEY1_ADDR);
endmodule

// File: rtl/wpg_key_slot.sv
module wpg_key_slot
  import wpg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLOT_ADDR = KEY0_ADDR,
  parameter logic [DATA_W-1:0] MAGIC     = KEY0_MAGIC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              match_o
);
  logic match_q;
  logic match_d;
  logic load_en;

  assign load_en = wr_en_i && (wr_addr_i == SLOT_ADDR);

  always_comb begin
    match_d = match_q;
    if (load_en) match_d = (wr_data_i == MAGIC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       match_q <= 1'b0;
    else if (load_en) match_q <= match_d;
  end

  assign match_o = match_q;

  a_r3_wrong_word_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == SLOT_ADDR && wr_data_i != MAGIC) |=> !match_o);
  a_r2_magic_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == SLOT_ADDR && wr_data_i == MAGIC) |=> match_o);
  a_r1_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_addr_i == SLOT_ADDR) |=> $stable(match_o));
endmodule

// File: rtl/wpg_write_gate.sv
module wpg_write_gate
  import wpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              unlocked_o
);
  logic rst_n_s;
  logic wr_prot, wr_key;
  logic rd_prot_unused, rd_key;
  logic k0_ok, k1_ok;
  logic unlocked;

  wpg_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  wpg_prot_decode u_wdec (.addr_i(wr_addr_i), .prot_o(wr_prot), .key_o(wr_key));
  wpg_prot_decode u_rdec (.addr_i(rd_addr_i), .prot_o(rd_prot_unused), .key_o(rd_key));

  wpg_key_slot #(.SLOT_ADDR(KEY0_ADDR), .MAGIC(KEY0_MAGIC)) u_key0 (
    .clk(clk), .rst_n(rst_n_s), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .match_o(k0_ok));
  wpg_key_slot #(.SLOT_ADDR(KEY1_ADDR), .MAGIC(KEY1_MAGIC)) u_key1 (
    .clk(clk), .rst_n(rst_n_s), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .match_o(k1_ok));

  assign unlocked   = k0_ok && k1_ok;
  assign unlocked_o = unlocked;

  always_comb begin
    wr_en_o = 1'b0;
    if (wr_en_i && !wr_key) wr_en_o = !wr_prot || unlocked;
  end

  assign wr_addr_o = wr_addr_i;
  assign wr_data_o = wr_data_i;
  assign rd_data_o = rd_key ? '0 : rd_data_i;

  a_r4_locked_drop: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en_i && wr_prot && !unlocked_o) |-> !wr_en_o);
  a_r7_key_absorbed: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en_i && wr_key) |-> !wr_en_o);
  a_r6_open_pass: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en_i && !wr_prot && !wr_key) |-> wr_en_o);
  a_r2_rise_after_key: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(unlocked_o) |-> $past(wr_en_i && wr_key));
endmodule

// File: tb/wpg_write_gate_test.sv
module wpg_write_gate_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en_i;
  logic [7:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [7:0]  rd_addr_i;
  logic [31:0] rd_data_i;
  logic        wr_en_o;
  logic [7:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic [31:0] rd_data_o;
  logic        unlocked_o;

  int checks = 0;
  int errors = 0;
  bit m_k0 = 0;
  bit m_k1 = 0;

  wpg_write_gate uut (.*);

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  function automatic bit is_prot(input logic [7:0] a);
    return (a <= 8'h18) || (a >= 8'h20 && a <= 8'h34) || (a >= 8'h44 && a <= 8'h48) ||
           (a == 8'h54) || (a >= 8'h60 && a <= 8'h68) || (a == 8'h7C) ||
           (a >= 8'h80 && a <= 8'h98);
  endfunction

  function automatic bit is_key(input logic [7:0] a);
    return (a == 8'h6C) || (a == 8'h70);
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(input string tag, input bit we, input logic [7:0] a,
                      input logic [31:0] d, input logic [7:0] ra);
    bit exp_we;
    logic [31:0] rd;
    rd = $urandom;
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; rd_addr_i = ra; rd_data_i = rd;
    #2;
    exp_we = we && !is_key(a) && (!is_prot(a) || (m_k0 && m_k1));
    check(tag, "unlocked_o", unlocked_o, m_k0 && m_k1);
    check(tag, "wr_en_o", wr_en_o, exp_we);
    if (exp_we) begin
      check(tag, "wr_addr_o", wr_addr_o, a);
      check(tag, "wr_data_o", wr_data_o, d);
    end
    check(is_key(ra) ? "R8" : tag, "rd_data_o", rd_data_o, is_key(ra) ? 0 : rd);
    @(posedge clk);
    if (we && a == 8'h6C) m_k0 = (d == 32'h83E70B13);
    if (we && a == 8'h70) m_k1 = (d == 32'h95A4F1E0);
    @(negedge clk);
  endtask

  localparam logic [31:0] M0 = 32'h83E70B13;
  localparam logic [31:0] M1 = 32'h95A4F1E0;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en_i = 0; wr_addr_i = 0; wr_data_i = 0; rd_addr_i = 0; rd_data_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state locked, idle
    step("R1", 0, 8'h00, 0, 8'h10);
    // R4: protected write dropped while locked; read of same reg in same cycle
    step("R4", 1, 8'h00, 32'h12, 8'h00);
    step("R4", 1, 8'h98, 32'h34, 8'h98);
    // R6: unprotected writes pass while locked
    step("R6", 1, 8'h40, 32'h1, 8'h40);
    step("R6", 1, 8'h1C, 32'h2, 8'h4C);
    // R7 and R8: key write absorbed, read of key in same cycle gives zero
    step("R7", 1, 8'h6C, M0, 8'h6C);
    // R10: one correct slot leaves the file locked
    step("R10", 1, 8'h14, 32'h55, 8'h70);
    step("R2", 1, 8'h70, M1, 8'h70);
    // R5: unlocked, protected writes forwarded
    step("R5", 1, 8'h98, 32'hA5A5, 8'h98);
    step("R9", 1, 8'h60, 32'h77, 8'h68);
    step("R6", 1, 8'h50, 32'h9, 8'h58);
    // R3: wrong word to key 1 relocks; very next protected write blocked
    step("R3", 1, 8'h70, 32'h0, 8'h6C);
    step("R3", 1, 8'h7C, 32'h3, 8'h7C);
    // R2: reload key 1 only
    step("R2", 1, 8'h70, M1, 8'h00);
    step("R5", 1, 8'h44, 32'h6, 8'h44);
    // R3: non-zero wrong word in key 0
    step("R3", 1, 8'h6C, M1, 8'h00);
    step("R3", 1, 8'h20, 32'h7, 8'h00);
    // R2: reverse order, both cleared first
    step("R3", 1, 8'h70, 32'h0, 8'h00);
    step("R2", 1, 8'h70, M1, 8'h00);
    step("R10", 1, 8'h34, 32'h8, 8'h00);
    step("R2", 1, 8'h6C, M0, 8'h00);
    step("R5", 1, 8'h34, 32'h8, 8'h00);
    // R9 boundaries while unlocked then locked
    step("R9", 1, 8'h19, 32'h1, 8'h00);
    step("R9", 1, 8'h99, 32'h1, 8'h00);
    step("R3", 1, 8'h6C, 32'h0, 8'h00);
    step("R9", 1, 8'h18, 32'h1, 8'h00);
    step("R9", 1, 8'h54, 32'h1, 8'h00);
    step("R9", 1, 8'h58, 32'h1, 8'h00);
    // Mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      a = $urandom;
      d = $urandom;
      if (sel == 0) begin a = 8'h6C; d = M0; end
      if (sel == 1) begin a = 8'h70; d = M1; end
      if (sel == 2) a = 8'h6C;
      if (sel == 3 && (i % 5 == 0)) a = 8'h70;
      step("R9", $urandom_range(0, 3) != 0, a, d, (sel > 6) ? 8'h70 : 8'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule